// File: doc/BRIEF.md
# Camera Pixel Capture with Luminance Conversion

This block sits in the pixel-clock domain behind a camera's parallel byte interface. The interface has a frame sync line, a line-valid line and an 8-bit data bus. Capture starts only after the camera has been configured and a controller has asked for a stream. It then waits for the frame sync line to fall, so that it always begins on a frame boundary. During a captured frame, bytes are taken on rising clock edges while the line-valid signal is high. Each line is limited to the configured image width, and each frame to the configured image height.

The block has two variants, selected at elaboration. In the luminance variant, byte pairs are joined into 16-bit 5-6-5 pixels. Each pixel is widened to 8 bits per colour and reduced to one 8-bit brightness value by a three-stage pipeline. In the raw variant, every accepted byte is passed on unchanged.

The result is a write strobe and a byte for a downstream FIFO. The write strobe is held back while the FIFO reports full, and a sticky overflow flag then marks the frame as damaged.

Top module: `cam_pix_capture`

## Requirements
- R1: After reset `wr_en` and `ovf_flag` are 0, and no write occurs unless `cfg_done` and `stream_req` have both been high at the same clock edge.
- R2: Once armed, bytes are ignored until a falling edge of `vsync` is seen (`vsync` high at one rising edge, low at the next).
- R3: A byte is taken only at a rising edge where `href` is high. Within a line, the first byte of each pair is the high byte (bits 15:8) of the 5-6-5 pixel (red in bits 15:11, green in 10:5, blue in 4:0).
- R4: In the luminance variant (`GRAY_EN`=1), each pixel yields one output byte. Red and blue are widened by appending their three top bits, and green by appending its two top bits, to give R8, G8 and B8. The output is (77·R8 + 150·G8 + 29·B8) >> 8.
- R5: In the luminance variant, `wr_en` for a pixel is high in the cycle after the third rising edge that follows the edge which took its low byte. Pixels come out in arrival order.
- R6: In the raw variant (`GRAY_EN`=0), every taken byte appears unchanged on `wr_data`, in order, with `wr_en` high in the cycle after the edge that took it.
- R7: Bytes beyond the first `IMG_W` pixels of a line (2·`IMG_W` bytes in the luminance variant, `IMG_W` bytes in the raw variant) are ignored. Lines after the first `IMG_H` lines of a frame are ignored.
- R8: If `stream_req` or `cfg_done` drops during a frame, the rest of that frame is still captured. Capture stops at the next falling edge of `vsync`.
- R9: `wr_en` is never high while `fifo_full` is high. A pixel that finds the FIFO full sets `ovf_flag`, which stays set until the next falling edge of `vsync`, where it clears.
- R10: In the luminance variant, a byte left without a partner when `href` falls is dropped. The next line starts a fresh pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Camera pixel clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cfg_done | input | 1 | Camera configuration finished |
| stream_req | input | 1 | Stream request from the control logic |
| vsync | input | 1 | Frame sync from the camera |
| href | input | 1 | Line-valid from the camera |
| pix_d | input | 8 | Camera data byte |
| fifo_full | input | 1 | Downstream FIFO full |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | FIFO write byte (luminance or raw byte) |
| ovf_flag | output | 1 | Sticky overflow for the current frame |

## Verification
The hardest state to reach from the ports is a stream request that drops in the middle of a frame. The bench lowers `stream_req` between two lines and expects the rest of that frame in full and nothing from the next frame. Overflow is produced by holding `fifo_full` across a whole frame. The bench then checks the flag before and after the next frame-sync fall.

The conversion arithmetic is checked by a sweep of a little over four thousand pixels through a 4×3 image. The pixels step through the 16-bit space by an odd stride. A second instance runs the raw variant on the same stimulus, and its expected bytes are built from the same model.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

   typedef enum logic [1:0] {
      CS_IDLE = 2'd0,
      CS_WAIT = 2'd1,
      CS_RUN  = 2'd2
   } cap_state_t;

   typedef struct packed {
      logic [4:0] r;
      logic [5:0] g;
      logic [4:0] b;
   } rgb565_t;

   localparam int unsigned LUMA_KR = 77;
   localparam int unsigned LUMA_KG = 150;
   localparam int unsigned LUMA_KB = 29;
   localparam int unsigned PROD_W  = 16;

endpackage

// File: rtl/cap_frame_ctrl.sv
module cap_frame_ctrl
   import cam_cap_pkg::*;
#(
   parameter int unsigned IMG_W   = 640,
   parameter int unsigned IMG_H   = 480,
   parameter int unsigned BYTES_PP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_done,
   input  logic stream_req,
   input  logic vsync,
   input  logic href,
   output logic byte_take,
   output logic frame_start
);

   localparam int unsigned LINE_BYTES = IMG_W * BYTES_PP;
   localparam int unsigned BC_W = $clog2(LINE_BYTES + 1);
   localparam int unsigned LC_W = $clog2(IMG_H + 1);

   cap_state_t       state_q, state_d;
   logic             vs_q, href_q;
   logic [BC_W-1:0]  byte_cnt;
   logic [LC_W-1:0]  line_cnt;
   logic             go, vs_fall, line_end;

   assign go       = cfg_done & stream_req;
   assign vs_fall  = vs_q & ~vsync;
   assign line_end = href_q & ~href;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CS_IDLE: if (go) state_d = CS_WAIT;
         CS_WAIT: begin
            if (!go)          state_d = CS_IDLE;
            else if (vs_fall) state_d = CS_RUN;
         end
         CS_RUN:  if (vs_fall) state_d = go ? CS_RUN : CS_IDLE;
         default: state_d = CS_IDLE;
      endcase
   end

   assign frame_start = vs_fall & go & (state_q != CS_IDLE);

   assign byte_take = (state_q == CS_RUN) & href
                    & (byte_cnt < BC_W'(LINE_BYTES))
                    & (line_cnt < LC_W'(IMG_H));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= CS_IDLE;
         vs_q     <= 1'b0;
         href_q   <= 1'b0;
         byte_cnt <= '0;
         line_cnt <= '0;
      end else begin
         state_q <= state_d;
         vs_q    <= vsync;
         href_q  <= href;
         if (frame_start) begin
            byte_cnt <= '0;
            line_cnt <= '0;
         end else if (line_end && state_q == CS_RUN) begin
            byte_cnt <= '0;
            if (line_cnt < LC_W'(IMG_H)) line_cnt <= line_cnt + 1'b1;
         end else if (byte_take) begin
            byte_cnt <= byte_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rgb_pair_pack.sv
module rgb_pair_pack
   import cam_cap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       href,
   input  logic       take,
   input  logic [7:0] din,
   output logic       pix_vld,
   output rgb565_t    pix
);

   logic       phase;
   logic [7:0] hi_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= 1'b0;
         hi_byte <= '0;
         pix_vld <= 1'b0;
         pix     <= '0;
      end else begin
         pix_vld <= 1'b0;
         if (!href) begin
            phase <= 1'b0;
         end else if (take) begin
            if (!phase) begin
               hi_byte <= din;
               phase   <= 1'b1;
            end else begin
               pix     <= rgb565_t'({hi_byte, din});
               pix_vld <= 1'b1;
               phase   <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/luma_pipe.sv
module luma_pipe
   import cam_cap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_vld,
   input  rgb565_t    in_pix,
   output logic       out_vld,
   output logic [7:0] out_y
);

   localparam int unsigned SUM_W = PROD_W + 2;

   logic [2:0]        vld_sr;
   logic [7:0]        r8, g8, b8;
   logic [PROD_W-1:0] pr, pg, pb;
   logic [SUM_W-1:0]  sum;

   assign sum = SUM_W'(pr) + SUM_W'(pg) + SUM_W'(pb);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_sr <= '0;
         r8     <= '0;
         g8     <= '0;
         b8     <= '0;
         pr     <= '0;
         pg     <= '0;
         pb     <= '0;
         out_y  <= '0;
      end else begin
         vld_sr <= {vld_sr[1:0], in_vld};
         // stage 1: widen each channel to 8 bits
         r8 <= {in_pix.r, in_pix.r[4:2]};
         g8 <= {in_pix.g, in_pix.g[5:4]};
         b8 <= {in_pix.b, in_pix.b[4:2]};
         // stage 2: weight each channel
         pr <= PROD_W'(r8 * LUMA_KR[7:0]);
         pg <= PROD_W'(g8 * LUMA_KG[7:0]);
         pb <= PROD_W'(b8 * LUMA_KB[7:0]);
         // stage 3: add and scale
         out_y <= sum[15:8];
      end
   end

   assign out_vld = vld_sr[2];

endmodule

// File: rtl/cam_pix_capture.sv
module cam_pix_capture
   import cam_cap_pkg::*;
#(
   parameter int unsigned IMG_W   = 640,
   parameter int unsigned IMG_H   = 480,
   parameter int unsigned GRAY_EN = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_done,
   input  logic       stream_req,
   input  logic       vsync,
   input  logic       href,
   input  logic [7:0] pix_d,
   input  logic       fifo_full,
   output logic       wr_en,
   output logic [7:0] wr_data,
   output logic       ovf_flag
);

   localparam int unsigned BYTES_PP = (GRAY_EN != 0) ? 2 : 1;

   if (IMG_W < 1 || IMG_H < 1) begin : g_bad_size
      $error("cam_pix_capture: IMG_W and IMG_H must be at least 1");
   end
   if (GRAY_EN > 1) begin : g_bad_mode
      $error("cam_pix_capture: GRAY_EN must be 0 or 1");
   end

   logic       byte_take, frame_start;
   logic       out_vld;
   logic [7:0] out_byte;

   cap_frame_ctrl #(
      .IMG_W   (IMG_W),
      .IMG_H   (IMG_H),
      .BYTES_PP(BYTES_PP)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_done   (cfg_done),
      .stream_req (stream_req),
      .vsync      (vsync),
      .href       (href),
      .byte_take  (byte_take),
      .frame_start(frame_start)
   );

   if (GRAY_EN != 0) begin : g_luma
      logic    pix_vld;
      rgb565_t pix;

      rgb_pair_pack u_pack (
         .clk    (clk),
         .rst_n  (rst_n),
         .href   (href),
         .take   (byte_take),
         .din    (pix_d),
         .pix_vld(pix_vld),
         .pix    (pix)
      );

      luma_pipe u_luma (
         .clk    (clk),
         .rst_n  (rst_n),
         .in_vld (pix_vld),
         .in_pix (pix),
         .out_vld(out_vld),
         .out_y  (out_byte)
      );
   end else begin : g_raw
      logic       raw_vld;
      logic [7:0] raw_byte;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            raw_vld  <= 1'b0;
            raw_byte <= '0;
         end else begin
            raw_vld <= byte_take;
            if (byte_take) raw_byte <= pix_d;
         end
      end

      assign out_vld  = raw_vld;
      assign out_byte = raw_byte;
   end

   assign wr_en   = out_vld & ~fifo_full;
   assign wr_data = out_byte;

   always_ff @(posedge clk) begin
      if (!rst_n)                    ovf_flag <= 1'b0;
      else if (frame_start)          ovf_flag <= 1'b0;
      else if (out_vld && fifo_full) ovf_flag <= 1'b1;
   end

endmodule

// File: rtl/cam_cap_chk.sv
module cam_cap_chk #(
   parameter int unsigned GRAY_EN = 1
) (
   input logic clk,
   input logic rst_n,
   input logic cfg_done,
   input logic stream_req,
   input logic vsync,
   input logic href,
   input logic fifo_full,
   input logic wr_en,
   input logic ovf_flag
);

   logic seen_arm, vs_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_arm <= 1'b0;
         vs_prev  <= 1'b0;
      end else begin
         vs_prev <= vsync;
         if (cfg_done && stream_req) seen_arm <= 1'b1;
      end
   end

   // R1
   no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_arm |-> !wr_en);

   // R9
   no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !fifo_full);

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !(vs_prev && !vsync)) |=> ovf_flag);

   // R9
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(fifo_full));

   if (GRAY_EN == 0) begin : g_raw_chk
      // R6
      raw_from_href_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |-> $past(href));
   end

endmodule

bind cam_pix_capture cam_cap_chk #(.GRAY_EN(GRAY_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_done  (cfg_done),
   .stream_req(stream_req),
   .vsync     (vsync),
   .href      (href),
   .fifo_full (fifo_full),
   .wr_en     (wr_en),
   .ovf_flag  (ovf_flag)
);

// File: tb/sim_cam_pix_capture.sv
`timescale 1ns/1ps
module sim_cam_pix_capture;

   localparam int W = 4;
   localparam int H = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_done = 1'b0, stream_req = 1'b0, vsync = 1'b0, href = 1'b0;
   logic [7:0] pix_d = '0;
   logic fifo_full = 1'b0;
   logic wr0, wr1, ovf0, ovf1;
   logic [7:0] wd0, wd1;

   int checks = 0;
   int fails  = 0;
   int pix_idx = 0;
   logic [7:0] obs0[$], obs1[$], exp0[$], exp1[$];

   always #2 clk = ~clk;

   cam_pix_capture #(.IMG_W(W), .IMG_H(H), .GRAY_EN(1)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .stream_req(stream_req),
      .vsync(vsync), .href(href), .pix_d(pix_d), .fifo_full(fifo_full),
      .wr_en(wr0), .wr_data(wd0), .ovf_flag(ovf0));

   cam_pix_capture #(.IMG_W(W), .IMG_H(H), .GRAY_EN(0)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .stream_req(stream_req),
      .vsync(vsync), .href(href), .pix_d(pix_d), .fifo_full(fifo_full),
      .wr_en(wr1), .wr_data(wd1), .ovf_flag(ovf1));

   always @(negedge clk) begin
      if (wr0) obs0.push_back(wd0);
      if (wr1) obs1.push_back(wd1);
   end

   function automatic logic [7:0] luma(input logic [15:0] p);
      int r8, g8, b8;
      r8 = (int'(p[15:11]) << 3) | (int'(p[15:11]) >> 2);
      g8 = (int'(p[10:5])  << 2) | (int'(p[10:5])  >> 4);
      b8 = (int'(p[4:0])   << 3) | (int'(p[4:0])   >> 2);
      return 8'((77 * r8 + 150 * g8 + 29 * b8) >> 8);
   endfunction

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // compare collected writes with the model and clear both
   task automatic compare(input string req);
      check({req, " luma count"}, obs0.size(), exp0.size());
      check({req, " raw count"},  obs1.size(), exp1.size());
      for (int i = 0; i < exp0.size() && i < obs0.size(); i++)
         check({req, " luma byte"}, obs0[i], exp0[i]);
      for (int i = 0; i < exp1.size() && i < obs1.size(); i++)
         check({req, " raw byte"}, obs1[i], exp1[i]);
      obs0.delete(); obs1.delete(); exp0.delete(); exp1.delete();
   endtask

   task automatic send_lines(input int lines, input int nbytes, input bit cap,
                             input int drop_after);
      logic [15:0] p;
      p = '0;
      for (int l = 0; l < lines; l++) begin
         for (int b = 0; b < nbytes; b++) begin
            if (b % 2 == 0) begin
               p = 16'(pix_idx * 4099);
               pix_idx++;
            end
            pix_d = (b % 2 == 0) ? p[15:8] : p[7:0];
            href  = 1'b1;
            if (cap && l < H) begin
               if (b < W) exp1.push_back(pix_d);
               if (b % 2 == 1 && b < 2 * W) exp0.push_back(luma(p));
            end
            tick();
         end
         href = 1'b0;
         if (l == drop_after) stream_req = 1'b0;
         repeat (2) tick();
      end
   endtask

   task automatic run_frame(input int lines, input int nbytes, input bit cap,
                            input int drop_after);
      vsync = 1'b1;
      repeat (3) tick();
      vsync = 1'b0;
      repeat (3) tick();
      send_lines(lines, nbytes, cap, drop_after);
      repeat (4) tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) tick();
      // R1: reset state
      check("R1 reset wr_en", int'(wr0 | wr1), 0);
      check("R1 reset ovf", int'(ovf0 | ovf1), 0);
      rst_n = 1'b1;
      tick();

      // R1: only one of the two arming conditions present
      stream_req = 1'b1;
      run_frame(H, 2 * W, 1'b0, -1);
      compare("R1 no cfg_done");
      stream_req = 1'b0; cfg_done = 1'b1;
      run_frame(H, 2 * W, 1'b0, -1);
      compare("R1 no stream_req");

      // R2: armed but no vsync fall yet
      stream_req = 1'b1;
      repeat (2) tick();
      send_lines(2, 2 * W, 1'b0, -1);
      repeat (4) tick();
      compare("R2 before vsync fall");

      // R3 R4 R5 R6: sweep of pixel values
      for (int f = 0; f < 345; f++) begin
         run_frame(H, 2 * W, 1'b1, -1);
         compare("R4 sweep");
      end

      // R7: long lines and extra lines
      run_frame(H + 2, 2 * W + 6, 1'b1, -1);
      compare("R7 limits");

      // R10: odd byte count per line
      run_frame(H, 2 * W - 1, 1'b1, -1);
      compare("R10 odd line");

      // R8: drop request mid-frame, rest of frame still captured
      run_frame(H, 2 * W, 1'b1, 0);
      compare("R8 finish frame");
      run_frame(H, 2 * W, 1'b0, -1);
      compare("R8 stopped");
      stream_req = 1'b1;
      run_frame(H, 2 * W, 1'b1, -1);
      compare("R8 rearm");

      // R9: FIFO full during a whole frame
      fifo_full = 1'b1;
      run_frame(H, 2 * W, 1'b0, -1);
      compare("R9 full no write");
      check("R9 ovf luma set", int'(ovf0), 1);
      check("R9 ovf raw set", int'(ovf1), 1);
      fifo_full = 1'b0;
      repeat (5) tick();
      check("R9 ovf sticky", int'(ovf0 & ovf1), 1);
      run_frame(H, 2 * W, 1'b1, -1);
      compare("R9 after full");
      check("R9 ovf cleared", int'(ovf0 | ovf1), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule